// File: doc/BRIEF.md
# Per-Hart Direct Interrupt Delivery Unit

This unit sits between a bank of interrupt sources and one processor hart when interrupts are delivered over wires rather than as messages. Each cycle it receives a vector of sources that are both pending and enabled, together with one routing word per source. The routing word names the destination hart and the urgency of that source. From the sources routed to its own hart, the unit picks the most urgent one and screens it against a software threshold. It then drives a registered external-interrupt line toward the hart.

Software controls the unit through a 32-byte register window. The window holds a delivery switch, a force bit, a threshold, a read-only view of the winning interrupt, and a claim register. Reading the claim register returns the current winner. One cycle later the unit emits a strobe that carries the winner's source number, so the pending logic upstream can retire that source. The force bit raises a pseudo-interrupt with identity 0, which is useful for checking that the path to the hart works.

Top module: `hart_direct_idc`

## Requirements
- R1: After synchronous reset, the following are all 0: the delivery switch, the force bit, the threshold, the read data, the clear strobe and the external-interrupt output.
- R2: The register offsets are 0 for the delivery switch (bit 0), 4 for force (bit 0), 8 for the threshold (bits 7:0), 24 for the top view and 28 for claim. Read data is zero-extended and appears on `reg_rdata` in the cycle after the read request, and is 0 in cycles with no read. Unmapped offsets read 0. Writes to offsets 24, 28 and unmapped offsets change nothing.
- R3: Source n (1 to NSRC-1) is a candidate only when its pending bit is set and bits [18+HART_W-1:18] of its routing word equal HART_IDX.
- R4: The effective priority is bits 7:0 of the routing word, with 0 read as 1. The smallest effective priority wins, and a tie goes to the lower source number.
- R5: A threshold of 0 screens nothing. A non-zero threshold T admits only effective priorities strictly below T.
- R6: The top view reads (id << 16) | priority, with the source number in bits 25:16 and the effective priority in bits 7:0. It reads 0 when no candidate survives the threshold.
- R7: A claim read returns the same value as the top view. When that value is non-zero, `clr_valid` pulses for exactly one cycle, together with the read data, and carries the winning source number on `clr_id`. No strobe is produced in any other case.
- R8: A claim that returns 0 clears the force bit. If a write to force occurs in the same cycle, the write takes effect instead.
- R9: In each cycle, `ext_irq` is set to delivery switch AND `domain_en` AND (a surviving candidate exists OR force is set). The value is registered, so it reflects the state one cycle earlier.
- R10: With delivery allowed and no candidate, writing 1 to force raises `ext_irq`. With the delivery switch at 0, force alone does not raise `ext_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| domain_en | input | 1 | Enable of the whole interrupt domain |
| src_pend | input | NSRC-1 | Pending-and-enabled flags, bit n for source n (1..NSRC-1) |
| src_target | input | 32*(NSRC-1) | Routing words, word n at bits [32n+31:32n] |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 5 | Byte offset inside the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| clr_valid | output | 1 | One-cycle strobe: retire the claimed source |
| clr_id | output | 10 | Source number to retire |
| ext_irq | output | 1 | External interrupt to the hart |

## Verification
The properties assume that a source's pending flag stays stable between clock edges. They also assume that the upstream pending logic drops a source only after it sees the clear strobe, or on its own terms, and never as a result of a glitch inside a cycle. The properties do not assume that reads and writes are exclusive. The stimulus nevertheless issues at most one register access per cycle, and it changes the pending and routing inputs only on the falling edge. After the bench sees a strobe, it clears the claimed source's pending flag itself, in the way a real pending unit would.

// File: rtl/hart_idc_pkg.sv
package hart_idc_pkg;
  localparam int ID_W     = 10;
  localparam int PRIO_W   = 8;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 32;
  localparam int HART_LSB = 18;
  localparam int ID_LSB   = 16;

  typedef enum logic [ADDR_W-1:0] {
    OFF_DELIV  = 5'd0,
    OFF_FORCE  = 5'd4,
    OFF_THRESH = 5'd8,
    OFF_TOP    = 5'd24,
    OFF_CLAIM  = 5'd28
  } idc_off_e;

  function automatic logic [DATA_W-1:0] pack_top(input logic [ID_W-1:0] id,
                                                 input logic [PRIO_W-1:0] prio);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ID_LSB +: ID_W] = id;
    w[PRIO_W-1:0]     = prio;
    return w;
  endfunction
endpackage

// File: rtl/hart_idc_select.sv
module hart_idc_select
  import hart_idc_pkg::*;
#(
  parameter int NSRC     = 32,
  parameter int HART_W   = 4,
  parameter int HART_IDX = 2
) (
  input  logic [NSRC-1:1]         pend,
  input  logic [NSRC*32-1:32]     tgt,
  input  logic [PRIO_W-1:0]       thresh,
  output logic                    found,
  output logic [ID_W-1:0]         best_id,
  output logic [PRIO_W-1:0]       best_prio
);
  logic [NSRC-1:1]   elig;
  logic [PRIO_W-1:0] eprio [1:NSRC-1];
  logic              unused_tgt;

  assign unused_tgt = ^tgt;

  for (genvar g = 1; g < NSRC; g++) begin : g_src
    logic [PRIO_W-1:0] raw;
    logic [HART_W-1:0] hart;
    assign raw      = tgt[g*32 +: PRIO_W];
    assign hart     = tgt[g*32 + HART_LSB +: HART_W];
    assign eprio[g] = (raw == '0) ? PRIO_W'(1) : raw;
    assign elig[g]  = pend[g] && (hart == HART_W'(HART_IDX)) &&
                      ((thresh == '0) || (eprio[g] < thresh));
  end

  always_comb begin
    found     = 1'b0;
    best_id   = '0;
    best_prio = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (elig[i] && (!found || (eprio[i] < best_prio))) begin
        found     = 1'b1;
        best_id   = ID_W'(i);
        best_prio = eprio[i];
      end
    end
  end
endmodule

// File: rtl/hart_idc_ctl.sv
module hart_idc_ctl
  import hart_idc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               found,
  input  logic [ID_W-1:0]    best_id,
  input  logic [PRIO_W-1:0]  best_prio,
  output logic               deliv_en,
  output logic               force_q,
  output logic [PRIO_W-1:0]  thresh,
  output logic [DATA_W-1:0]  rdata,
  output logic               clr_valid,
  output logic [ID_W-1:0]    clr_id
);
  logic [DATA_W-1:0] top_word;
  logic              claim;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:PRIO_W];
  assign top_word     = found ? pack_top(best_id, best_prio) : '0;
  assign claim        = reg_rd && (reg_addr == OFF_CLAIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      deliv_en  <= 1'b0;
      force_q   <= 1'b0;
      thresh    <= '0;
      rdata     <= '0;
      clr_valid <= 1'b0;
      clr_id    <= '0;
    end else begin
      rdata     <= '0;
      clr_valid <= 1'b0;
      if (reg_rd) begin
        case (reg_addr)
          OFF_DELIV:         rdata <= DATA_W'(deliv_en);
          OFF_FORCE:         rdata <= DATA_W'(force_q);
          OFF_THRESH:        rdata <= DATA_W'(thresh);
          OFF_TOP, OFF_CLAIM: rdata <= top_word;
          default:           rdata <= '0;
        endcase
      end
      if (claim && found) begin
        clr_valid <= 1'b1;
        clr_id    <= best_id;
      end
      if (claim && !found) force_q <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          OFF_DELIV:  deliv_en <= reg_wdata[0];
          OFF_FORCE:  force_q  <= reg_wdata[0];
          OFF_THRESH: thresh   <= reg_wdata[PRIO_W-1:0];
          default:    ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hart_direct_idc.sv
module hart_direct_idc
  import hart_idc_pkg::*;
#(
  parameter int NSRC     = 32,
  parameter int HART_W   = 4,
  parameter int HART_IDX = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  domain_en,
  input  logic [NSRC-1:1]       src_pend,
  input  logic [NSRC*32-1:32]   src_target,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [4:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  clr_valid,
  output logic [9:0]            clr_id,
  output logic                  ext_irq
);
  logic              found;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;
  logic              deliv_en;
  logic              force_q;
  logic [PRIO_W-1:0] thresh;

  hart_idc_select #(.NSRC(NSRC), .HART_W(HART_W), .HART_IDX(HART_IDX)) u_select (
    .pend(src_pend), .tgt(src_target), .thresh(thresh),
    .found(found), .best_id(best_id), .best_prio(best_prio)
  );

  hart_idc_ctl u_ctl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .found(found), .best_id(best_id), .best_prio(best_prio),
    .deliv_en(deliv_en), .force_q(force_q), .thresh(thresh), .rdata(reg_rdata),
    .clr_valid(clr_valid), .clr_id(clr_id)
  );

  always_ff @(posedge clk) begin
    if (rst) ext_irq <= 1'b0;
    else     ext_irq <= deliv_en && domain_en && (found || force_q);
  end

  // R4: a winner never carries priority 0
  assert_prio_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    found |-> best_prio != '0);

  // R5: the winner always sits strictly under a non-zero threshold
  assert_under_thresh_R5: assert property (@(posedge clk) disable iff (rst)
    (found && thresh != '0) |-> best_prio < thresh);

  // R7: a strobe only follows a claim read, and never names source 0
  assert_clr_from_claim_R7: assert property (@(posedge clk) disable iff (rst)
    clr_valid |-> $past(reg_rd && reg_addr == 5'd28));
  assert_clr_id_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    clr_valid |-> clr_id != '0);

  // R8: an empty claim with no concurrent write leaves force cleared
  assert_force_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 5'd28 && !found && !reg_wr) |=> !force_q);

  // R9: the interrupt line needs both enables in the previous cycle
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    ext_irq |-> $past(deliv_en && domain_en));
endmodule

// File: tb/hart_direct_idc_bench.sv
module hart_direct_idc_bench;
  localparam int NSRC     = 32;
  localparam int HART_W   = 4;
  localparam int HART_IDX = 2;

  logic clk = 0;
  logic rst = 1;
  logic domain_en = 0;
  logic [NSRC-1:1] pend = '0;
  logic [31:0] tgt_arr [1:NSRC-1];
  logic [NSRC*32-1:32] tgt_flat;
  logic reg_wr = 0, reg_rd = 0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic clr_valid;
  logic [9:0] clr_id;
  logic ext_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb
    for (int i = 1; i < NSRC; i++) tgt_flat[i*32 +: 32] = tgt_arr[i];

  hart_direct_idc #(.NSRC(NSRC), .HART_W(HART_W), .HART_IDX(HART_IDX)) u_hart_direct_idc (
    .clk(clk), .rst(rst), .domain_en(domain_en), .src_pend(pend), .src_target(tgt_flat),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .clr_valid(clr_valid), .clr_id(clr_id), .ext_irq(ext_irq)
  );

  // Behavioural reference model
  bit m_deliv = 0, m_force = 0;
  int m_thresh = 0;
  bit exp_irq = 0, exp_clr = 0;
  int exp_clr_id = 0;
  logic [31:0] exp_rdata = 0;
  bit mf;
  int mid, mpr;
  logic [31:0] mtop;

  task automatic pick(output bit f, output int id, output int pr);
    f = 0; id = 0; pr = 0;
    for (int n = 1; n < NSRC; n++) begin
      int p, h;
      p = tgt_arr[n] & 32'hFF;
      if (p == 0) p = 1;
      h = (tgt_arr[n] >> 18) & ((1 << HART_W) - 1);
      if (pend[n] && h == HART_IDX && (m_thresh == 0 || p < m_thresh))
        if (!f || p < pr) begin f = 1; id = n; pr = p; end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_deliv <= 0; m_force <= 0; m_thresh <= 0;
      exp_irq <= 0; exp_clr <= 0; exp_clr_id <= 0; exp_rdata <= 0;
    end else begin
      pick(mf, mid, mpr);
      mtop = mf ? ((mid << 16) | mpr) : 32'd0;
      exp_irq   <= m_deliv && domain_en && (mf || m_force);
      exp_rdata <= 0;
      exp_clr   <= 0;
      if (reg_rd) begin
        case (reg_addr)
          5'd0:  exp_rdata <= {31'd0, m_deliv};
          5'd4:  exp_rdata <= {31'd0, m_force};
          5'd8:  exp_rdata <= m_thresh;
          5'd24, 5'd28: exp_rdata <= mtop;
          default: exp_rdata <= 0;
        endcase
        if (reg_addr == 5'd28) begin
          if (mf) begin exp_clr <= 1; exp_clr_id <= mid; end
          else m_force <= 0;
        end
      end
      if (reg_wr) begin
        case (reg_addr)
          5'd0: m_deliv  <= reg_wdata[0];
          5'd4: m_force  <= reg_wdata[0];
          5'd8: m_thresh <= reg_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks += 3;
      if (ext_irq !== exp_irq) begin
        errors++; $display("FAIL R9 ext_irq act=%0b exp=%0b", ext_irq, exp_irq);
      end
      if (reg_rdata !== exp_rdata) begin
        errors++; $display("FAIL R2 rdata act=%08h exp=%08h", reg_rdata, exp_rdata);
      end
      if (clr_valid !== exp_clr || (exp_clr && clr_id !== 10'(exp_clr_id))) begin
        errors++;
        $display("FAIL R7 clr act=%0b/%0d exp=%0b/%0d", clr_valid, clr_id, exp_clr, exp_clr_id);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic rd(input logic [4:0] a);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  function automatic logic [31:0] tw(input int hart, input int prio);
    return (32'(hart) << 18) | 32'(prio);
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 1; i < NSRC; i++) tgt_arr[i] = tw(0, 5);
    repeat (3) tick();
    rst = 0;
    tick();
    // R1: reset state
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 ext_irq", {31'd0, ext_irq}, 0);
    chk("R1 clr", {31'd0, clr_valid}, 0);
    rd(5'd0);  chk("R1 deliv", reg_rdata, 0);
    rd(5'd4);  chk("R1 force", reg_rdata, 0);
    rd(5'd8);  chk("R1 thresh", reg_rdata, 0);

    wr(5'd0, 32'h1); domain_en = 1;
    rd(5'd0);  chk("R2 deliv read", reg_rdata, 1);
    rd(5'd24); chk("R6 empty top", reg_rdata, 0);
    chk("R9 idle irq", {31'd0, ext_irq}, 0);

    tgt_arr[5] = tw(2, 10); tgt_arr[9] = tw(2, 3); tgt_arr[12] = tw(1, 1);
    pend[5] = 1; pend[9] = 1; pend[12] = 1;
    rd(5'd24); chk("R3 R4 R6 top", reg_rdata, 32'h0009_0003);
    tick();    chk("R9 irq raised", {31'd0, ext_irq}, 1);

    tgt_arr[7] = tw(2, 3); pend[7] = 1;
    rd(5'd24); chk("R4 tie lower id", reg_rdata, 32'h0007_0003);
    tgt_arr[4] = tw(2, 0); pend[4] = 1;
    rd(5'd24); chk("R4 zero prio as 1", reg_rdata, 32'h0004_0001);

    wr(5'd8, 32'd1);
    rd(5'd24); chk("R5 thresh 1 masks all", reg_rdata, 0);
    chk("R5 irq off", {31'd0, ext_irq}, 0);
    wr(5'd8, 32'd2);
    rd(5'd24); chk("R5 thresh 2", reg_rdata, 32'h0004_0001);
    pend[4] = 0; wr(5'd8, 32'd3);
    rd(5'd24); chk("R5 thresh 3 strict", reg_rdata, 0);
    wr(5'd8, 32'd0);

    rd(5'd28); chk("R7 claim value", reg_rdata, 32'h0007_0003);
    chk("R7 strobe", {31'd0, clr_valid}, 1);
    chk("R7 strobe id", {22'd0, clr_id}, 7);
    pend[7] = 0;
    tick();    chk("R7 strobe one cycle", {31'd0, clr_valid}, 0);
    rd(5'd24); chk("R7 next winner", reg_rdata, 32'h0009_0003);

    wr(5'd0, 32'h0); tick();
    chk("R9 deliv off", {31'd0, ext_irq}, 0);
    wr(5'd0, 32'h1); domain_en = 0; tick(); tick();
    chk("R9 domain off", {31'd0, ext_irq}, 0);
    domain_en = 1;

    pend = '0;
    wr(5'd4, 32'h1); tick();
    chk("R10 force irq", {31'd0, ext_irq}, 1);
    rd(5'd4);  chk("R2 force read", reg_rdata, 1);
    rd(5'd28); chk("R8 claim zero", reg_rdata, 0);
    chk("R8 no strobe", {31'd0, clr_valid}, 0);
    rd(5'd4);  chk("R8 force cleared", reg_rdata, 0);
    chk("R8 irq dropped", {31'd0, ext_irq}, 0);
    wr(5'd0, 32'h0); wr(5'd4, 32'h1); tick(); tick();
    chk("R10 force no deliv", {31'd0, ext_irq}, 0);
    wr(5'd4, 32'h0); wr(5'd0, 32'h1);

    wr(5'd8, 32'h1FF);
    rd(5'd8);  chk("R2 thresh width", reg_rdata, 32'hFF);
    wr(5'd8, 32'h0);
    rd(5'd12); chk("R2 unmapped", reg_rdata, 0);
    wr(5'd24, 32'hFFFF_FFFF); wr(5'd12, 32'hFFFF_FFFF);
    rd(5'd8);  chk("R2 ignored writes", reg_rdata, 0);
    rd(5'd0);  chk("R2 ignored writes deliv", reg_rdata, 1);

    // Randomised phase, compared cycle by cycle against the model
    for (int c = 0; c < 4000; c++) begin
      int act;
      @(negedge clk);
      if (exp_clr) pend[exp_clr_id] = 0;
      reg_rd = 0; reg_wr = 0;
      if ($urandom_range(0, 3) == 0) begin
        int n;
        n = $urandom_range(1, NSRC - 1);
        pend[n] = ~pend[n];
        tgt_arr[n] = tw(($urandom_range(0, 2) == 0) ? 1 : HART_IDX, $urandom_range(0, 7));
      end
      if ($urandom_range(0, 63) == 0) domain_en = ~domain_en;
      act = $urandom_range(0, 9);
      if (act < 4) begin
        reg_rd = 1;
        case ($urandom_range(0, 6))
          0: reg_addr = 5'd0; 1: reg_addr = 5'd4; 2: reg_addr = 5'd8;
          3: reg_addr = 5'd24; 4, 5: reg_addr = 5'd28; default: reg_addr = 5'd16;
        endcase
      end else if (act < 6) begin
        reg_wr = 1;
        case ($urandom_range(0, 3))
          0: begin reg_addr = 5'd0; reg_wdata = ($urandom_range(0, 4) != 0) ? 32'h1 : 32'h0; end
          1: begin reg_addr = 5'd4; reg_wdata = 32'($urandom_range(0, 1)); end
          2: begin reg_addr = 5'd8; reg_wdata = 32'($urandom_range(0, 9)); end
          default: begin reg_addr = 5'd24; reg_wdata = $urandom; end
        endcase
      end
    end
    @(negedge clk); reg_rd = 0; reg_wr = 0;
    tick(); tick();

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule